// File: doc/BRIEF.md
# Bus-Mastering Block Copy Engine

This engine copies a run of 32-bit words from a peripheral's outgoing word stream into memory, so the processor does not handle each word. Software loads a physical byte address and a word count, then writes the control register with its go bit set. The engine checks the configuration first: the whole run must sit inside one 4 KiB page, the address must be word aligned and the count must be non-zero. A configuration that fails this check never reaches the bus. It is refused at once with the error flag set.

When a job is accepted, the engine raises its bus request and waits for the grant. While it holds the bus, each word taken from the peripheral stream becomes one memory write. The write address starts at the programmed address and advances by 4 bytes per word. After the last word the engine drops the request and sets the done flag. The interrupt line is the OR of the done and error flags, so it fires only on completion or failure. Any later write to the control register clears both flags, and that also clears the interrupt.

Both data paths use valid/ready handshakes. A word moves only in a cycle where both sides of that handshake are high. The engine stores no words itself: `src_ready` repeats `mem_wr_ready` while the engine owns the bus, and `mem_wr_valid` repeats `src_valid`. When the source is empty, the engine keeps the bus and issues no write. When memory applies back-pressure, the address and data stay stable.

Top module: `dma_bus_master`

## Requirements
- R1: After reset, `bus_req`, `irq`, `mem_wr_valid` and `src_ready` are low and the status register reads 0.
- R2: A control write (select 2) with bit 0 set and an acceptable configuration raises `bus_req` in the next cycle. No memory write is presented until `bus_grant` is high.
- R3: Once granted, word k of the job is written at start address + 4*k, carrying the k-th word accepted from the stream, and every write stays in the starting 4 KiB page.
- R4: While the bus is held, `mem_wr_valid` follows `src_valid` and `src_ready` follows `mem_wr_ready`. An empty source keeps the bus requested and issues no write. A stalled write keeps its address.
- R5: The cycle after the last word is accepted, `bus_req` is low, the done flag is set and `irq` is high.
- R6: A go is refused when (start address mod 4096) + 4*count > 4096. A refusal sets the error flag and `irq` in the next cycle and never raises `bus_req`. A run that ends exactly at the page end is accepted.
- R7: A go with count 0, or with a start address whose low two bits are not zero, is refused in the same way as in R6.
- R8: If `bus_grant` falls while a job is moving data, no write is presented from that cycle on. In the next cycle `bus_req` is low and the error flag and `irq` are set.
- R9: Any write to the control register clears the done and error flags, and with them `irq`.
- R10: A go while a job is active is ignored. The job keeps its address and its remaining count.
- R11: Register map for reads: select 0 is the start address, select 1 is the word count, select 2 is the status with bit 0 busy, bit 1 done and bit 2 error, and select 3 is the address of the next word to write. Writes to select 0 and 1 load the address and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| src_valid | input | 1 | Peripheral word available |
| src_data | input | 32 | Peripheral word |
| src_ready | output | 1 | Engine takes the peripheral word |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant |
| mem_wr_valid | output | 1 | Memory write presented |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | 32 | Memory write byte address |
| mem_wr_data | output | 32 | Memory write data |
| irq | output | 1 | Completion or error interrupt |

## Verification
The copy path is first run with a steady source and memory that is always ready. This shows that addresses advance by 4 and that words arrive in order. A second run inserts a gap in the source every third cycle and a stall in memory every fourth cycle. It shows that the engine keeps the bus while idle, and that a stalled write does not advance or drop a word. That run ends exactly at a page end, while a run one word later in the page must be refused, which pins the boundary comparison. A go issued in the middle of a job and a grant withdrawn during a job show that a restart and a normal finish can each be told apart from the correct behaviour.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_REQ  = 2'd1,
    MV_XFER = 2'd2
  } mv_state_t;

  localparam logic [1:0] SEL_ADDR   = 2'd0;
  localparam logic [1:0] SEL_COUNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL   = 2'd2;
  localparam logic [1:0] SEL_NEXT   = 2'd3;

  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_ERR  = 2;
endpackage

// File: rtl/dma_page_guard.sv
// Decides whether a programmed job may start: non-zero count, word aligned,
// and contained in a single page.
module dma_page_guard #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_cnt,
  output logic              cfg_ok
);
  localparam int ASHIFT = $clog2(DATA_W / 8);
  localparam int SUM_W  = PAGE_BITS + CNT_W + ASHIFT + 1;
  localparam logic [SUM_W-1:0] PAGE_SIZE = SUM_W'(1) << PAGE_BITS;

  logic [SUM_W-1:0] end_off;
  logic             align_ok;
  logic             fits;

  assign end_off = SUM_W'(start_addr[PAGE_BITS-1:0]) + (SUM_W'(word_cnt) << ASHIFT);
  assign fits    = (end_off <= PAGE_SIZE);

  generate
    if (ASHIFT > 0) begin : g_align
      assign align_ok = (start_addr[ASHIFT-1:0] == '0);
    end else begin : g_noalign
      assign align_ok = 1'b1;
    end
  endgenerate

  assign cfg_ok = fits && align_ok && (word_cnt != '0);
endmodule

// File: rtl/dma_mover.sv
// Bus ownership and word movement: request, wait for grant, stream words.
module dma_mover
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  word_cnt,
  input  logic              bus_grant,
  output logic              bus_req,
  input  logic              src_valid,
  output logic              src_ready,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              busy,
  output logic              fin,
  output logic              abort
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  mv_state_t         state;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  left;
  logic              owning;
  logic              fire;

  assign owning    = (state == MV_XFER) && bus_grant;
  assign wr_valid  = owning && src_valid;
  assign src_ready = owning && wr_ready;
  assign fire      = owning && src_valid && wr_ready;
  assign bus_req   = (state != MV_IDLE);
  assign busy      = bus_req;
  assign wr_addr   = cur_addr;
  assign fin       = fire && (left == CNT_W'(1));
  assign abort     = (state == MV_XFER) && !bus_grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= MV_IDLE;
      cur_addr <= '0;
      left     <= '0;
    end else begin
      case (state)
        MV_IDLE: begin
          if (start) begin
            cur_addr <= base_addr;
            left     <= word_cnt;
            state    <= MV_REQ;
          end
        end
        MV_REQ: begin
          if (bus_grant) state <= MV_XFER;
        end
        MV_XFER: begin
          if (!bus_grant) begin
            state <= MV_IDLE;
          end else if (fire) begin
            cur_addr <= cur_addr + STEP;
            left     <= left - CNT_W'(1);
            if (left == CNT_W'(1)) state <= MV_IDLE;
          end
        end
        default: state <= MV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_regfile.sv
// Software-visible configuration, launch decode and status flags.
module dma_regfile
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cfg_ok,
  input  logic              busy,
  input  logic              fin,
  input  logic              abort,
  input  logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [CNT_W-1:0]  cfg_count,
  output logic              start,
  output logic              done_flag,
  output logic              err_flag
);
  logic ctl_wr;
  logic go;
  logic reject;

  assign ctl_wr = reg_wr && (reg_sel == SEL_CTRL);
  assign go     = ctl_wr && reg_wdata[0] && !busy;
  assign start  = go && cfg_ok;
  assign reject = go && !cfg_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_addr  <= '0;
      cfg_count <= '0;
    end else if (reg_wr) begin
      if (reg_sel == SEL_ADDR)  cfg_addr  <= reg_wdata[ADDR_W-1:0];
      if (reg_sel == SEL_COUNT) cfg_count <= reg_wdata[CNT_W-1:0];
    end
  end

  // Clear on control write first; a set event in the same cycle wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      if (ctl_wr) begin
        done_flag <= 1'b0;
        err_flag  <= 1'b0;
      end
      if (fin) done_flag <= 1'b1;
      if (abort || reject) err_flag <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_ADDR:  reg_rdata = DATA_W'(cfg_addr);
      SEL_COUNT: reg_rdata = DATA_W'(cfg_count);
      SEL_CTRL: begin
        reg_rdata[ST_BUSY] = busy;
        reg_rdata[ST_DONE] = done_flag;
        reg_rdata[ST_ERR]  = err_flag;
      end
      default:   reg_rdata = DATA_W'(next_addr);
    endcase
  end
endmodule

// File: rtl/dma_bus_master.sv
module dma_bus_master #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              irq
);
  logic [ADDR_W-1:0] cfg_addr;
  logic [CNT_W-1:0]  cfg_count;
  logic              cfg_ok;
  logic              mv_start;
  logic              mv_busy;
  logic              mv_fin;
  logic              mv_abort;
  logic              done_flag;
  logic              err_flag;

  dma_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_ok(cfg_ok),
    .busy(mv_busy), .fin(mv_fin), .abort(mv_abort), .next_addr(mem_wr_addr),
    .cfg_addr(cfg_addr), .cfg_count(cfg_count), .start(mv_start),
    .done_flag(done_flag), .err_flag(err_flag)
  );

  dma_page_guard #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
                   .PAGE_BITS(PAGE_BITS)) u_guard (
    .start_addr(cfg_addr), .word_cnt(cfg_count), .cfg_ok(cfg_ok)
  );

  dma_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_mover (
    .clk(clk), .rst_n(rst_n), .start(mv_start), .base_addr(cfg_addr),
    .word_cnt(cfg_count), .bus_grant(bus_grant), .bus_req(bus_req),
    .src_valid(src_valid), .src_ready(src_ready), .wr_valid(mem_wr_valid),
    .wr_ready(mem_wr_ready), .wr_addr(mem_wr_addr), .busy(mv_busy),
    .fin(mv_fin), .abort(mv_abort)
  );

  assign mem_wr_data = src_data;
  assign irq         = done_flag || err_flag;
endmodule

// File: rtl/dma_bus_master_chk.sv
module dma_bus_master_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] base,
  input logic              bus_req,
  input logic              bus_grant,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic              err_flag,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  logic [ADDR_W-PAGE_BITS-1:0] job_page;
  logic                        fire;

  assign fire = mem_wr_valid && mem_wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) job_page <= '0;
    else if (start) job_page <= base[ADDR_W-1:PAGE_BITS];
  end

  // R2
  wr_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (bus_grant && bus_req));

  // R3
  same_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (mem_wr_addr[ADDR_W-1:PAGE_BITS] == job_page));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fire) && mem_wr_valid) |-> (mem_wr_addr == $past(mem_wr_addr) + STEP));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> $stable(mem_wr_addr));

  // R5
  release_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> irq);

  // R9
  quiet_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !irq);

  // R6
  refuse_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err_flag) && !$past(bus_req)) |-> !bus_req);
endmodule

bind dma_bus_master dma_bus_master_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(mv_start), .base(cfg_addr),
  .bus_req(bus_req), .bus_grant(bus_grant), .mem_wr_valid(mem_wr_valid),
  .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
  .err_flag(err_flag), .irq(irq)
);

// File: tb/test_dma_bus_master.sv
module test_dma_bus_master;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        src_valid = 1'b0;
  logic [31:0] src_data = '0;
  logic        src_ready;
  logic        bus_req;
  logic        bus_grant = 1'b0;
  logic        mem_wr_valid;
  logic        mem_wr_ready = 1'b0;
  logic [31:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_bus_master i_dma_bus_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_valid(src_valid),
    .src_data(src_data), .src_ready(src_ready), .bus_req(bus_req),
    .bus_grant(bus_grant), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .irq(irq)
  );

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] sel, output logic [31:0] val);
    reg_sel = sel;
    #1;
    val = reg_rdata;
  endtask

  task automatic check_status(input string req, input logic [2:0] exp);
    logic [31:0] v;
    read_reg(2'd2, v);
    check_eq(req, "status", v, {29'd0, exp});
    check_eq(req, "irq", {31'd0, irq}, {31'd0, exp[2] | exp[1]});
  endtask

  // Streams n words of a granted job; word index starts at first.
  task automatic run_words(input logic [31:0] base, input int first, input int n,
                           input bit gaps, input string req);
    int got = 0;
    int cyc = 0;
    while (got < n && cyc < 400) begin
      src_valid    = !(gaps && (cyc % 3 == 1));
      mem_wr_ready = !(gaps && (cyc % 4 == 2));
      src_data     = 32'hC0DE_0000 + 32'(first + got);
      #1;
      check_eq(req, "bus_req held", {31'd0, bus_req}, 32'd1);
      check_eq(req, "wr_valid follows src", {31'd0, mem_wr_valid}, {31'd0, src_valid});
      check_eq(req, "src_ready follows mem", {31'd0, src_ready}, {31'd0, mem_wr_ready});
      if (mem_wr_valid) begin
        check_eq(req, "addr", mem_wr_addr, base + 32'(4 * (first + got)));
        check_eq(req, "data", mem_wr_data, 32'hC0DE_0000 + 32'(first + got));
        if (mem_wr_ready) got++;
      end
      cyc++;
      @(negedge clk);
    end
    src_valid = 1'b0;
    mem_wr_ready = 1'b0;
    check_eq(req, "words moved", 32'(got), 32'(n));
  endtask

  task automatic t_reset;
    check_eq("R1", "bus_req", {31'd0, bus_req}, 32'd0);
    check_eq("R1", "mem_wr_valid", {31'd0, mem_wr_valid}, 32'd0);
    check_eq("R1", "src_ready", {31'd0, src_ready}, 32'd0);
    check_status("R1", 3'b000);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    reg_write(2'd0, 32'h1000_0100);
    reg_write(2'd1, 32'd4);
    read_reg(2'd0, v); check_eq("R11", "addr reg", v, 32'h1000_0100);
    read_reg(2'd1, v); check_eq("R11", "count reg", v, 32'd4);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    reg_write(2'd2, 32'd1);
    check_eq("R2", "bus_req after go", {31'd0, bus_req}, 32'd1);
    check_status("R2", 3'b001);
    src_valid = 1'b1; mem_wr_ready = 1'b1;
    repeat (2) begin
      #1 check_eq("R2", "no write before grant", {31'd0, mem_wr_valid}, 32'd0);
      @(negedge clk);
    end
    src_valid = 1'b0;
    bus_grant = 1'b1;
    @(negedge clk);
    run_words(32'h1000_0100, 0, 4, 1'b0, "R3");
    check_eq("R5", "bus released", {31'd0, bus_req}, 32'd0);
    check_status("R5", 3'b010);
    read_reg(2'd3, v); check_eq("R11", "next addr", v, 32'h1000_0110);
    bus_grant = 1'b0;
  endtask

  task automatic t_clear;
    reg_write(2'd2, 32'd0);
    check_status("R9", 3'b000);
  endtask

  task automatic t_stall_boundary;
    reg_write(2'd0, 32'h2000_0FE8);
    reg_write(2'd1, 32'd6);
    reg_write(2'd2, 32'd1);
    check_eq("R6", "exact page end accepted", {31'd0, bus_req}, 32'd1);
    bus_grant = 1'b1;
    @(negedge clk);
    run_words(32'h2000_0FE8, 0, 6, 1'b1, "R4");
    check_status("R5", 3'b010);
    bus_grant = 1'b0;
    t_clear();
  endtask

  task automatic t_page_cross;
    reg_write(2'd0, 32'h2000_0FEC);
    reg_write(2'd2, 32'd1);
    check_eq("R6", "no request on cross", {31'd0, bus_req}, 32'd0);
    check_status("R6", 3'b100);
    repeat (3) @(negedge clk);
    check_eq("R6", "still no request", {31'd0, bus_req}, 32'd0);
    t_clear();
  endtask

  task automatic t_bad_cfg;
    reg_write(2'd0, 32'h3000_0000);
    reg_write(2'd1, 32'd0);
    reg_write(2'd2, 32'd1);
    check_eq("R7", "zero count no request", {31'd0, bus_req}, 32'd0);
    check_status("R7", 3'b100);
    t_clear();
    reg_write(2'd0, 32'h3000_0002);
    reg_write(2'd1, 32'd1);
    reg_write(2'd2, 32'd1);
    check_eq("R7", "misaligned no request", {31'd0, bus_req}, 32'd0);
    check_status("R7", 3'b100);
    t_clear();
  endtask

  task automatic t_go_busy;
    reg_write(2'd0, 32'h4000_0040);
    reg_write(2'd1, 32'd3);
    reg_write(2'd2, 32'd1);
    bus_grant = 1'b1;
    @(negedge clk);
    run_words(32'h4000_0040, 0, 1, 1'b0, "R10");
    reg_write(2'd2, 32'd1);
    check_eq("R10", "still busy", {31'd0, bus_req}, 32'd1);
    run_words(32'h4000_0040, 1, 2, 1'b0, "R10");
    check_eq("R10", "ends after original count", {31'd0, bus_req}, 32'd0);
    check_status("R10", 3'b010);
    bus_grant = 1'b0;
    t_clear();
  endtask

  task automatic t_grant_loss;
    reg_write(2'd0, 32'h5000_0000);
    reg_write(2'd1, 32'd8);
    reg_write(2'd2, 32'd1);
    bus_grant = 1'b1;
    @(negedge clk);
    run_words(32'h5000_0000, 0, 2, 1'b0, "R8");
    bus_grant = 1'b0;
    src_valid = 1'b1;
    mem_wr_ready = 1'b1;
    #1;
    check_eq("R8", "no write without grant", {31'd0, mem_wr_valid}, 32'd0);
    check_eq("R8", "no take without grant", {31'd0, src_ready}, 32'd0);
    @(negedge clk);
    src_valid = 1'b0;
    check_eq("R8", "bus released", {31'd0, bus_req}, 32'd0);
    check_status("R8", 3'b100);
    t_clear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_basic();
    t_clear();
    t_stall_boundary();
    t_page_cross();
    t_bad_cfg();
    t_go_busy();
    t_grant_loss();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule